// File: doc/BRIEF.md
# Transmit Buffer Request Scheduler

This block keeps the control and status of eight message buffers for a CAN controller. Each buffer is set up as either a transmit or a receive buffer. Software writes a control byte per buffer, and two buffers share each 16-bit register. The scheduler picks which waiting transmit buffer goes to the protocol engine next. It takes back the engine's result strobes and updates the buffer's status flags. It also reacts to incoming remote frames that match a buffer.

Software queues a buffer by setting its send-request bit. The scheduler presents the best waiting buffer on an offer port, and the engine takes it with a start pulse. From then until the engine reports a result, the offer is frozen. Clearing a send-request bit that is still set raises an abort request toward the engine. A success result clears the request bit. Lost arbitration and bus error only flag the event, so the buffer is offered again.

Top module: `txSched`

## Requirements
- R1: After reset every control register reads 0, `offerValid` is 0 and `abortReq` is 0.
- R2: Register k holds buffer 2k in bits 7:0 and buffer 2k+1 in bits 15:8. Each byte reads as: bit 7 direction (1 = transmit), bit 6 aborted, bit 5 lost arbitration, bit 4 bus error, bit 3 send request, bit 2 auto-remote enable, bits 1:0 priority.
- R3: While the engine is idle, the offer is registered one cycle after the state it reflects. It names the buffer with direction 1 and send request 1 that has the highest priority (3 is highest, 0 is lowest). Ties go to the lowest buffer number. A buffer with direction 0 is never offered.
- R4: A `engStart` pulse while `offerValid` is 1 makes the engine busy. While busy, the offer is held. Any `resValid` pulse ends the busy state, and the offer is recomputed on the next cycle.
- R5: A success result (`resKind` 0) clears the send-request bit of buffer `resIdx` and leaves its status flags as they were.
- R6: A write with send request 0 to a buffer whose send request is 1 sets `abortReq` for that buffer. The abort request stays set until a success or abort result for that buffer, or until software sets the request again. An abort result (`resKind` 1) sets the aborted flag.
- R7: A lost-arbitration result (`resKind` 2) sets bit 5, and a bus-error result (`resKind` 3) sets bit 4. In both cases the send-request bit stays 1.
- R8: Setting the send-request bit, by a write or by a remote frame, clears all three status flags of that buffer.
- R9: `rtrHit` with `rtrIdx` = i sets the send request of buffer i when its auto-remote bit is 1. When that bit is 0, the buffer is left unchanged.
- R10: Writes to bits 6:4 of a byte have no effect. Those flags change only through engine results and request setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register index for the write |
| wrData | input | 16 | Write data, two buffer bytes |
| rdAddr | input | 2 | Register index for the read |
| rdData | output | 16 | Read data, combinational |
| offerValid | output | 1 | A transmit buffer is offered |
| offerIdx | output | 3 | Offered buffer number |
| engStart | input | 1 | Engine takes the offered buffer |
| resValid | input | 1 | Engine result strobe |
| resKind | input | 2 | 0 success, 1 aborted, 2 lost arbitration, 3 bus error |
| resIdx | input | 3 | Buffer the result belongs to |
| abortReq | output | 8 | Per-buffer abort request to the engine |
| rtrHit | input | 1 | Matching remote frame received |
| rtrIdx | input | 3 | Buffer the remote frame matched |

## Verification
The assertions assume the engine follows three rules. It pulses `engStart` only while idle with a valid offer. It sends `resValid` only while busy. It reports results only for the buffer it took. The bench engine keeps an idle/busy flag of its own to follow these rules. It starts only on a valid offer and returns each result on the index it took. Register writes and remote frames are unconstrained and may land in the same cycle as results. In that case the register write takes precedence, then the remote frame, then the result.

// File: rtl/txSchedPkg.sv
package txSchedPkg;
  localparam int BYTE_W = 8;
  localparam int PRI_W  = 2;

  // byte layout positions, decoded by software
  localparam int B_DIR  = 7;
  localparam int B_ABT  = 6;
  localparam int B_LOST = 5;
  localparam int B_ERR  = 4;
  localparam int B_REQ  = 3;
  localparam int B_AUTO = 2;

  typedef enum logic [1:0] {
    RES_DONE  = 2'd0,
    RES_ABORT = 2'd1,
    RES_LOST  = 2'd2,
    RES_ERR   = 2'd3
  } resKindE;

  // per-buffer strobes from control to datapath
  typedef struct packed {
    logic wrCtl;
    logic rtrSet;
    logic resDone;
    logic resAbt;
    logic resLost;
    logic resErr;
  } bufStbT;
endpackage

// File: rtl/txSchedCtrl.sv
module txSchedCtrl
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 8,
  localparam int NUM_REG = NUM_BUF / 2,
  localparam int AW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int IW = $clog2(NUM_BUF)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [AW-1:0]                  wrAddr,
  input  logic                           engStart,
  input  logic                           resValid,
  input  logic [1:0]                     resKind,
  input  logic [IW-1:0]                  resIdx,
  input  logic                           rtrHit,
  input  logic [IW-1:0]                  rtrIdx,
  input  logic [NUM_BUF-1:0]             dirV,
  input  logic [NUM_BUF-1:0]             reqV,
  input  logic [NUM_BUF-1:0]             autoV,
  input  logic [NUM_BUF-1:0][PRI_W-1:0]  priV,
  output bufStbT [NUM_BUF-1:0]           stb,
  output logic                           offerValid,
  output logic [IW-1:0]                  offerIdx,
  output logic                           busy
);
  resKindE kind;
  assign kind = resKindE'(resKind);

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : gStb
      logic resHere;
      assign resHere          = resValid && (resIdx == IW'(g));
      assign stb[g].wrCtl     = wrEn && (wrAddr == AW'(g / 2));
      assign stb[g].rtrSet    = rtrHit && (rtrIdx == IW'(g)) && autoV[g];
      assign stb[g].resDone   = resHere && (kind == RES_DONE);
      assign stb[g].resAbt    = resHere && (kind == RES_ABORT);
      assign stb[g].resLost   = resHere && (kind == RES_LOST);
      assign stb[g].resErr    = resHere && (kind == RES_ERR);
    end
  endgenerate

  // highest priority pending transmit buffer, lowest index on tie
  logic             pickValid;
  logic [IW-1:0]    pickIdx;
  logic [PRI_W-1:0] pickPri;
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    pickPri   = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (dirV[i] && reqV[i] && (!pickValid || priV[i] > pickPri)) begin
        pickValid = 1'b1;
        pickIdx   = IW'(i);
        pickPri   = priV[i];
      end
    end
  end

  logic taken;
  assign taken = engStart && offerValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      offerValid <= 1'b0;
      offerIdx   <= '0;
    end else begin
      if (busy) begin
        if (resValid) busy <= 1'b0;
      end else if (taken) begin
        busy <= 1'b1;
      end
      if (!busy && !taken) begin
        offerValid <= pickValid;
        offerIdx   <= pickIdx;
      end
    end
  end
endmodule

// File: rtl/txSchedData.sv
module txSchedData
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 8,
  localparam int NUM_REG = NUM_BUF / 2,
  localparam int AW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int RW = 2 * BYTE_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bufStbT [NUM_BUF-1:0]           stb,
  input  logic [RW-1:0]                  wrData,
  input  logic [AW-1:0]                  rdAddr,
  output logic [RW-1:0]                  rdData,
  output logic [NUM_BUF-1:0]             dirV,
  output logic [NUM_BUF-1:0]             reqV,
  output logic [NUM_BUF-1:0]             autoV,
  output logic [NUM_BUF-1:0][PRI_W-1:0]  priV,
  output logic [NUM_BUF-1:0]             abtV,
  output logic [NUM_BUF-1:0]             abortReq
);
  logic [NUM_BUF-1:0][BYTE_W-1:0] rdByte;

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : gBuf
      logic [BYTE_W-1:0] wb;
      logic lostQ, errQ;
      assign wb = wrData[BYTE_W*(g%2) +: BYTE_W];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dirV[g]     <= 1'b0;
          reqV[g]     <= 1'b0;
          autoV[g]    <= 1'b0;
          priV[g]     <= '0;
          abtV[g]     <= 1'b0;
          lostQ       <= 1'b0;
          errQ        <= 1'b0;
          abortReq[g] <= 1'b0;
        end else begin
          // engine results first, software last wins
          if (stb[g].resDone) begin
            reqV[g]     <= 1'b0;
            abortReq[g] <= 1'b0;
          end
          if (stb[g].resAbt) begin
            abtV[g]     <= 1'b1;
            abortReq[g] <= 1'b0;
          end
          if (stb[g].resLost) lostQ <= 1'b1;
          if (stb[g].resErr)  errQ  <= 1'b1;
          if (stb[g].rtrSet) begin
            reqV[g] <= 1'b1;
            abtV[g] <= 1'b0;
            lostQ   <= 1'b0;
            errQ    <= 1'b0;
          end
          if (stb[g].wrCtl) begin
            dirV[g]  <= wb[B_DIR];
            autoV[g] <= wb[B_AUTO];
            priV[g]  <= wb[PRI_W-1:0];
            reqV[g]  <= wb[B_REQ];
            if (wb[B_REQ]) begin
              abtV[g]     <= 1'b0;
              lostQ       <= 1'b0;
              errQ        <= 1'b0;
              abortReq[g] <= 1'b0;
            end else if (reqV[g]) begin
              abortReq[g] <= 1'b1;
            end
          end
        end
      end

      assign rdByte[g] = {dirV[g], abtV[g], lostQ, errQ,
                          reqV[g], autoV[g], priV[g]};
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (rdAddr == AW'(i / 2)) rdData[BYTE_W*(i%2) +: BYTE_W] = rdByte[i];
    end
  end
endmodule

// File: rtl/txSched.sv
module txSched
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 8,
  localparam int NUM_REG = NUM_BUF / 2,
  localparam int AW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int IW = $clog2(NUM_BUF),
  localparam int RW = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [RW-1:0]      wrData,
  input  logic [AW-1:0]      rdAddr,
  output logic [RW-1:0]      rdData,
  output logic               offerValid,
  output logic [IW-1:0]      offerIdx,
  input  logic               engStart,
  input  logic               resValid,
  input  logic [1:0]         resKind,
  input  logic [IW-1:0]      resIdx,
  output logic [NUM_BUF-1:0] abortReq,
  input  logic               rtrHit,
  input  logic [IW-1:0]      rtrIdx
);
  bufStbT [NUM_BUF-1:0]          stb;
  logic [NUM_BUF-1:0]            dirV, reqV, autoV, abtV;
  logic [NUM_BUF-1:0][PRI_W-1:0] priV;
  logic                          busy;

  txSchedCtrl #(.NUM_BUF(NUM_BUF)) ctrlI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .engStart(engStart), .resValid(resValid), .resKind(resKind),
    .resIdx(resIdx), .rtrHit(rtrHit), .rtrIdx(rtrIdx),
    .dirV(dirV), .reqV(reqV), .autoV(autoV), .priV(priV),
    .stb(stb), .offerValid(offerValid), .offerIdx(offerIdx), .busy(busy)
  );

  txSchedData #(.NUM_BUF(NUM_BUF)) dataI (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dirV(dirV), .reqV(reqV),
    .autoV(autoV), .priV(priV), .abtV(abtV), .abortReq(abortReq)
  );
endmodule

// File: rtl/txSchedChk.sv
module txSchedChk #(
  parameter int NUM_BUF = 8,
  localparam int IW = $clog2(NUM_BUF)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               engStart,
  input logic               offerValid,
  input logic [IW-1:0]      offerIdx,
  input logic               resValid,
  input logic [1:0]         resKind,
  input logic [NUM_BUF-1:0] abortReq,
  input logic               busy,
  input logic [NUM_BUF-1:0] dirV,
  input logic [NUM_BUF-1:0] reqV,
  input logic [NUM_BUF-1:0] abtV
);
  logic [NUM_BUF-1:0] pendQ, abReqQ, abtQ;
  logic idleQ, wrQ, abtResQ;

  always_ff @(posedge clk) begin
    pendQ   <= dirV & reqV;
    abReqQ  <= abortReq;
    abtQ    <= abtV;
    idleQ   <= !busy && !(engStart && offerValid);
    wrQ     <= wrEn;
    abtResQ <= resValid && (resKind == 2'd1);
  end

  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && idleQ) |-> pendQ[offerIdx]); // R3
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && offerValid && !busy) |=> (offerValid && $stable(offerIdx))); // R4
  AST_RESULT_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && resValid) |=> !busy); // R4
  AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((abortReq & ~abReqQ) != '0) |-> wrQ); // R6
  AST_ABORTED_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rstN)
    ((abtV & ~abtQ) != '0) |-> abtResQ); // R10
endmodule

bind txSched txSchedChk #(.NUM_BUF(NUM_BUF)) chkI (.*);

// File: tb/txSched_tb.sv
`timescale 1ns/1ps
module txSched_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic offerValid;
  logic [2:0] offerIdx;
  logic engStart = 1'b0;
  logic resValid = 1'b0;
  logic [1:0] resKind = '0;
  logic [2:0] resIdx = '0;
  logic [7:0] abortReq;
  logic rtrHit = 1'b0;
  logic [2:0] rtrIdx = '0;

  always #2.5 clk = ~clk;

  txSched dut_i (.*);

  int nChk = 0;
  int nFail = 0;

  // behavioural reference state
  int mDir[8], mAbt[8], mLost[8], mErr[8], mReq[8], mAuto[8], mPri[8], mAbReq[8];
  int mBusy = 0, mOffV = 0, mOffI = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mByte(int i);
    return {mDir[i][0], mAbt[i][0], mLost[i][0], mErr[i][0],
            mReq[i][0], mAuto[i][0], mPri[i][1:0]};
  endfunction

  task automatic modelStep();
    int oReq[8];
    int oAuto[8];
    int best, bestPri, startOk;
    for (int i = 0; i < 8; i++) begin oReq[i] = mReq[i]; oAuto[i] = mAuto[i]; end
    best = -1; bestPri = -1;
    for (int i = 0; i < 8; i++)
      if (mDir[i] != 0 && mReq[i] != 0 && mPri[i] > bestPri) begin best = i; bestPri = mPri[i]; end
    startOk = (engStart && mOffV != 0) ? 1 : 0;
    if (mBusy == 0 && startOk == 0) begin
      mOffV = (best >= 0) ? 1 : 0;
      mOffI = (best >= 0) ? best : 0;
    end
    if (mBusy != 0) begin
      if (resValid) mBusy = 0;
    end else if (startOk != 0) mBusy = 1;
    for (int i = 0; i < 8; i++) begin
      if (resValid && resIdx == 3'(i)) begin
        case (resKind)
          2'd0: begin mReq[i] = 0; mAbReq[i] = 0; end
          2'd1: begin mAbt[i] = 1; mAbReq[i] = 0; end
          2'd2: mLost[i] = 1;
          default: mErr[i] = 1;
        endcase
      end
      if (rtrHit && rtrIdx == 3'(i) && oAuto[i] != 0) begin
        mReq[i] = 1; mAbt[i] = 0; mLost[i] = 0; mErr[i] = 0;
      end
      if (wrEn && int'(wrAddr) == i / 2) begin
        logic [7:0] b;
        b = wrData[8*(i%2) +: 8];
        mDir[i] = b[7]; mAuto[i] = b[2]; mPri[i] = b[1:0];
        if (b[3]) begin
          mReq[i] = 1; mAbt[i] = 0; mLost[i] = 0; mErr[i] = 0; mAbReq[i] = 0;
        end else begin
          if (oReq[i] != 0) mAbReq[i] = 1;
          mReq[i] = 0;
        end
      end
    end
  endtask

  task automatic compareAll();
    logic [7:0] ab;
    for (int k = 0; k < 4; k++) begin
      rdAddr = 2'(k);
      #0.1;
      chk("R2 register image", rdData, {mByte(2*k+1), mByte(2*k)});
    end
    chk("R3 offerValid", {15'd0, offerValid}, 16'(mOffV));
    if (mOffV != 0) chk("R3 offerIdx", {13'd0, offerIdx}, 16'(mOffI));
    for (int i = 0; i < 8; i++) ab[i] = mAbReq[i][0];
    chk("R6 abortReq", {8'd0, abortReq}, {8'd0, ab});
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    #0.5;
    compareAll();
    wrEn = 0; engStart = 0; resValid = 0; rtrHit = 0;
  endtask

  task automatic rd(input int k, output logic [15:0] v);
    rdAddr = 2'(k);
    #0.1;
    v = rdData;
  endtask

  task automatic doWrite(int a, logic [15:0] d);
    wrEn = 1; wrAddr = 2'(a); wrData = d; tick();
  endtask

  task automatic doResult(int idx, int kind);
    resValid = 1; resIdx = 3'(idx); resKind = 2'(kind); tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int eBusy, eIdx;
    for (int i = 0; i < 8; i++) begin
      mDir[i] = 0; mAbt[i] = 0; mLost[i] = 0; mErr[i] = 0;
      mReq[i] = 0; mAuto[i] = 0; mPri[i] = 0; mAbReq[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #0.5;
    // R1 reset state
    for (int k = 0; k < 4; k++) begin rd(k, v); chk("R1 reset register", v, 16'h0000); end
    chk("R1 reset offerValid", {15'd0, offerValid}, 16'd0);
    chk("R1 reset abortReq", {8'd0, abortReq}, 16'd0);

    // buffer 0: tx pri2 req; buffer 1: rx with req set (never offered)
    doWrite(0, 16'h0B8A);
    rd(0, v); chk("R2 packing reg0", v, 16'h0B8A);
    // buffer 2: tx pri3 req; buffer 3 gets only status bits written
    doWrite(1, 16'h708B);
    rd(1, v); chk("R10 status bits ignored", v, 16'h008B);
    chk("R3 rx buffer skipped", {13'd0, offerIdx}, 16'd0);
    tick();
    chk("R3 highest priority", {13'd0, offerIdx}, 16'd2);
    // engine takes buffer 2, then software clears its request
    engStart = 1; tick();
    doWrite(1, 16'h0083);
    chk("R6 abort request raised", {8'd0, abortReq}, 16'h0004);
    chk("R4 offer held while busy", {13'd0, offerIdx}, 16'd2);
    doResult(2, 1);
    rd(1, v); chk("R6 aborted flag set", v, 16'h00C3);
    chk("R6 abort request dropped", {8'd0, abortReq}, 16'h0000);
    doWrite(2, 16'h008A);
    tick();
    chk("R3 tie lowest index", {13'd0, offerIdx}, 16'd0);
    engStart = 1; tick();
    doResult(0, 2);
    rd(0, v); chk("R7 lost arbitration flag", v, 16'h0BAA);
    tick();
    chk("R7 rescheduled after loss", {13'd0, offerIdx}, 16'd0);
    engStart = 1; tick();
    doResult(0, 3);
    rd(0, v); chk("R7 bus error flag", v, 16'h0BBA);
    tick();
    engStart = 1; tick();
    doResult(0, 0);
    rd(0, v); chk("R5 success clears request", v, 16'h0BB2);
    tick();
    chk("R5 next buffer offered", {13'd0, offerIdx}, 16'd4);
    doWrite(0, 16'h0B8A);
    rd(0, v); chk("R8 flags cleared by request", v, 16'h0B8A);
    // remote frames: buffer 6 auto on, buffer 7 auto off
    doWrite(3, 16'h8084);
    rtrHit = 1; rtrIdx = 3'd6; tick();
    rd(3, v); chk("R9 auto remote sets request", v, 16'h808C);
    rtrHit = 1; rtrIdx = 3'd7; tick();
    rd(3, v); chk("R9 auto off unchanged", v, 16'h808C);

    // mixed traffic against the reference model
    eBusy = 0; eIdx = 0;
    repeat (3000) begin
      if ($urandom % 4 == 0) begin
        wrEn = 1;
        wrAddr = 2'($urandom % 4);
        wrData = 16'($urandom);
        if ($urandom % 2 == 0) wrData = wrData | 16'h8080;
      end
      if ($urandom % 8 == 0) begin rtrHit = 1; rtrIdx = 3'($urandom % 8); end
      if (eBusy == 0) begin
        if (mOffV != 0 && $urandom % 3 == 0) begin
          engStart = 1; eIdx = mOffI; eBusy = 1;
        end
      end else if ($urandom % 4 == 0) begin
        resValid = 1; resIdx = 3'(eIdx); resKind = 2'($urandom % 4); eBusy = 0;
      end
      tick();
    end
    summary();
    $finish;
  end
endmodule